// File: doc/BRIEF.md
# Serial Shift and Rotate Unit

This unit shifts or rotates an 8-bit or 16-bit operand by a count and produces the result together with carry, overflow, sign, zero and parity flags. It moves the operand by one bit position on each clock, so an operation by N positions takes N clocks after it is accepted. The carry is threaded through every step exactly as the selected operation defines, including the two forms that rotate through the carry bit.

The caller presents the operand, the incoming carry, the current overflow/sign/zero/parity flags, the operation code, the width select and two count sources (an immediate field and a count register), then pulses `start`. The unit answers with a one-cycle `done` pulse; the result and flags stay on the outputs until the next accepted start. Operand fetch and write-back belong to the caller.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation codes 4 and 6 both shift left: each step moves the active-width top bit into CF and enters a zero at bit 0.
- R2: Operation code 5 shifts right: each step moves bit 0 into CF and enters a zero at the active-width top bit.
- R3: Operation code 7 shifts right arithmetically: each step moves bit 0 into CF and leaves the active-width top bit unchanged.
- R4: Code 0 rotates left and code 1 rotates right; each step copies the bit leaving the operand into CF and into the vacated end.
- R5: Code 2 rotates left through carry and code 3 rotates right through carry; each step moves the leaving bit into CF and the previous CF into the vacated end, so CF and operand act as one ring of width+1 bits.
- R6: When `cnt_from_cl` is 1 the count is `cl_val`, otherwise `cnt_imm`; the unused source has no effect.
- R7: With count N, `done` is high for exactly the one cycle after the N-th clock edge following the edge that accepts `start`; N = 0 gives `done` right after the accepting edge with the operand (masked to width) as result and CF, OF, SF, ZF, PF equal to the inputs.
- R8: `wide` = 0 selects 8 bits (result bits 15:8 are zero), `wide` = 1 selects 16 bits. For N > 0 and codes 2 to 7, SF is the active-width top result bit, ZF is 1 when the active-width result is zero, PF is 1 when result bits 7:0 hold an even number of ones.
- R9: For codes 0 and 1 with N > 0, SF, ZF and PF equal the values of `sf_in`, `zf_in`, `pf_in` at the accepted start.
- R10: For N > 0, OF after left operations is the top result bit XOR CF; after codes 1, 3 and 5 it is the XOR of the two top result bits; after code 7 it is 0.
- R11: A `start` pulse while `busy` is high is ignored and does not alter the running operation.
- R12: After reset `done` and `busy` are 0 and result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 3 | Operation code |
| wide | input | 1 | 1 = 16-bit, 0 = 8-bit operand |
| cnt_from_cl | input | 1 | Count source select |
| cnt_imm | input | CNT_W | Immediate count |
| cl_val | input | CNT_W | Count register value |
| operand | input | 16 | Value to shift |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| sf_in | input | 1 | Incoming sign flag |
| zf_in | input | 1 | Incoming zero flag |
| pf_in | input | 1 | Incoming parity flag |
| result | output | 16 | Shifted value |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Parity flag |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |

## Verification
Every result and flag is due in the cycle after the N-th clock edge that follows the accepting edge, and only then. The bench drives on falling edges, then counts rising edges until it sees `done` at a falling edge, requiring that count to equal N before it compares result and flags, which are computed arithmetically from whole-word shifts and rotations modulo the width or width+1. A zero count must complete right after the accepting edge.

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic             wide,
  input  logic             cnt_from_cl,
  input  logic [CNT_W-1:0] cnt_imm,
  input  logic [CNT_W-1:0] cl_val,
  input  logic [15:0]      operand,
  input  logic             cf_in,
  input  logic             of_in,
  input  logic             sf_in,
  input  logic             zf_in,
  input  logic             pf_in,
  output logic [15:0]      result,
  output logic             cf,
  output logic             of,
  output logic             sf,
  output logic             zf,
  output logic             pf,
  output logic             done,
  output logic             busy
);
  localparam logic [2:0] OP_ROL = 3'd0;
  localparam logic [2:0] OP_ROR = 3'd1;
  localparam logic [2:0] OP_RCL = 3'd2;
  localparam logic [2:0] OP_RCR = 3'd3;
  localparam logic [2:0] OP_SAR = 3'd7;

  logic [15:0]      val_q, nxt;
  logic             c_q, nxt_c;
  logic [CNT_W-1:0] rem_q;
  logic [2:0]       op_q;
  logic             wide_q, busy_q, done_q;
  logic             of_q, sf_q, zf_q, pf_q;
  logic             sfk_q, zfk_q, pfk_q;
  logic             fill_l, fill_r, top;
  logic             n_top, n_sub, n_zero, n_par, n_of;

  wire [CNT_W-1:0] cnt       = cnt_from_cl ? cl_val : cnt_imm;
  wire [15:0]      opnd      = wide ? operand : {8'h00, operand[7:0]};
  wire             go_left   = ~op_q[0];
  wire             plain_rot = (op_q == OP_ROL) || (op_q == OP_ROR);
  wire             accept    = start && !busy_q;

  assign top = wide_q ? val_q[15] : val_q[7];

  always_comb begin
    fill_l = 1'b0;
    fill_r = 1'b0;
    case (op_q)
      OP_ROL:  fill_l = top;
      OP_RCL:  fill_l = c_q;
      OP_ROR:  fill_r = val_q[0];
      OP_RCR:  fill_r = c_q;
      OP_SAR:  fill_r = top;
      default: ;
    endcase
  end

  always_comb begin
    if (go_left) begin
      nxt   = {val_q[14:0], fill_l};
      nxt_c = top;
      if (!wide_q) nxt[15:8] = 8'h00;
    end else begin
      nxt   = {1'b0, val_q[15:1]};
      nxt_c = val_q[0];
      if (wide_q) nxt[15] = fill_r;
      else begin
        nxt[15:8] = 8'h00;
        nxt[7]    = fill_r;
      end
    end
  end

  assign n_top  = wide_q ? nxt[15] : nxt[7];
  assign n_sub  = wide_q ? nxt[14] : nxt[6];
  assign n_zero = wide_q ? (nxt == 16'h0000) : (nxt[7:0] == 8'h00);
  assign n_par  = ~^nxt[7:0];
  assign n_of   = go_left ? (n_top ^ nxt_c)
                          : ((op_q == OP_SAR) ? 1'b0 : (n_top ^ n_sub));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      c_q    <= 1'b0;
      rem_q  <= '0;
      op_q   <= '0;
      wide_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      of_q   <= 1'b0;
      sf_q   <= 1'b0;
      zf_q   <= 1'b0;
      pf_q   <= 1'b0;
      sfk_q  <= 1'b0;
      zfk_q  <= 1'b0;
      pfk_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        val_q  <= opnd;
        c_q    <= cf_in;
        rem_q  <= cnt;
        op_q   <= op;
        wide_q <= wide;
        sfk_q  <= sf_in;
        zfk_q  <= zf_in;
        pfk_q  <= pf_in;
        if (cnt == '0) begin
          done_q <= 1'b1;
          of_q   <= of_in;
          sf_q   <= sf_in;
          zf_q   <= zf_in;
          pf_q   <= pf_in;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        val_q <= nxt;
        c_q   <= nxt_c;
        rem_q <= rem_q - 1'b1;
        if (rem_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          of_q   <= n_of;
          sf_q   <= plain_rot ? sfk_q : n_top;
          zf_q   <= plain_rot ? zfk_q : n_zero;
          pf_q   <= plain_rot ? pfk_q : n_par;
        end
      end
    end
  end

  assign result = val_q;
  assign cf     = c_q;
  assign of     = of_q;
  assign sf     = sf_q;
  assign zf     = zf_q;
  assign pf     = pf_q;
  assign done   = done_q;
  assign busy   = busy_q;
endmodule

// File: rtl/shift_rotate_unit_checker.sv
module shift_rotate_unit_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [2:0]       op,
  input logic             wide,
  input logic             cnt_from_cl,
  input logic [CNT_W-1:0] cnt_imm,
  input logic [CNT_W-1:0] cl_val,
  input logic [15:0]      operand,
  input logic             cf_in,
  input logic             of_in,
  input logic             sf_in,
  input logic             zf_in,
  input logic             pf_in,
  input logic [15:0]      result,
  input logic             cf,
  input logic             of,
  input logic             sf,
  input logic             zf,
  input logic             pf,
  input logic             done,
  input logic             busy
);
  logic        armed, lo_zero, lo_wide, lo_cf, lo_sf, lo_zf, lo_pf, lo_of;
  logic [2:0]  lo_op;
  logic [15:0] lo_opnd;

  wire [CNT_W-1:0] sel_cnt = cnt_from_cl ? cl_val : cnt_imm;
  wire lo_rot = (lo_op == 3'd0) || (lo_op == 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; lo_zero <= 1'b0; lo_wide <= 1'b0; lo_cf <= 1'b0;
      lo_sf <= 1'b0; lo_zf <= 1'b0; lo_pf <= 1'b0; lo_of <= 1'b0;
      lo_op <= '0; lo_opnd <= '0;
    end else if (start && !busy) begin
      armed   <= 1'b1;
      lo_zero <= (sel_cnt == '0);
      lo_wide <= wide;
      lo_cf   <= cf_in;
      lo_of   <= of_in;
      lo_sf   <= sf_in;
      lo_zf   <= zf_in;
      lo_pf   <= pf_in;
      lo_op   <= op;
      lo_opnd <= wide ? operand : {8'h00, operand[7:0]};
    end
  end

  p_zero_count_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && sel_cnt == '0) |=> done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_progress_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  p_zero_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && armed && lo_zero) |-> (result == lo_opnd && cf == lo_cf && of == lo_of));

  p_rot_keeps_szp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && armed && !lo_zero && lo_rot) |-> (sf == lo_sf && zf == lo_zf && pf == lo_pf));

  p_sar_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && armed && !lo_zero && lo_op == 3'd7) |-> !of);

  p_byte_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && armed && !lo_wide) |-> (result[15:8] == 8'h00));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && armed && !lo_zero && !lo_rot) |->
      (zf == (lo_wide ? (result == 16'h0000) : (result[7:0] == 8'h00))));

  p_reset_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed) |-> (!done && !busy && result == 16'h0000));
endmodule

bind shift_rotate_unit shift_rotate_unit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
  .cnt_from_cl(cnt_from_cl), .cnt_imm(cnt_imm), .cl_val(cl_val),
  .operand(operand), .cf_in(cf_in), .of_in(of_in), .sf_in(sf_in),
  .zf_in(zf_in), .pf_in(pf_in), .result(result), .cf(cf), .of(of),
  .sf(sf), .zf(zf), .pf(pf), .done(done), .busy(busy)
);

// File: tb/sim_shift_rotate_unit.sv
module sim_shift_rotate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic        wide = 1'b0, cnt_from_cl = 1'b0;
  logic [7:0]  cnt_imm = '0, cl_val = '0;
  logic [15:0] operand = '0;
  logic        cf_in = 0, of_in = 0, sf_in = 0, zf_in = 0, pf_in = 0;
  logic [15:0] result;
  logic        cf, of, sf, zf, pf, done, busy;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  shift_rotate_unit #(.CNT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
    .cnt_from_cl(cnt_from_cl), .cnt_imm(cnt_imm), .cl_val(cl_val),
    .operand(operand), .cf_in(cf_in), .of_in(of_in), .sf_in(sf_in),
    .zf_in(zf_in), .pf_in(pf_in), .result(result), .cf(cf), .of(of),
    .sf(sf), .zf(zf), .pf(pf), .done(done), .busy(busy)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [2:0] o, input bit w16, input int n, input logic [15:0] v_in,
                       input bit c, input logic [3:0] fi,
                       output logic [15:0] r, output bit ecf, eof, esf, ezf, epf);
    int w, k;
    longint mask, v, x, m, rr, sv, top;
    w = w16 ? 16 : 8;
    mask = (64'd1 << w) - 1;
    v = longint'(v_in) & mask;
    if (n == 0) begin
      r = 16'(v); ecf = c; {eof, esf, ezf, epf} = fi;
      return;
    end
    rr = 0; ecf = 0;
    case (o)
      3'd0: begin k = n % w; rr = ((v << k) | (v >> (w - k))) & mask; ecf = rr[0]; end
      3'd1: begin k = n % w; rr = ((v >> k) | (v << (w - k))) & mask; ecf = bit'((rr >> (w-1)) & 1); end
      3'd2, 3'd3: begin
        m = (64'd1 << (w + 1)) - 1;
        x = (longint'(c) << w) | v;
        k = n % (w + 1);
        if (o == 3'd2) x = ((x << k) | (x >> (w + 1 - k))) & m;
        else           x = ((x >> k) | (x << (w + 1 - k))) & m;
        rr = x & mask; ecf = bit'((x >> w) & 1);
      end
      3'd4, 3'd6: begin
        rr  = (n >= w) ? 0 : ((v << n) & mask);
        ecf = (n <= w) ? bit'((v >> (w - n)) & 1) : 1'b0;
      end
      3'd5: begin
        rr  = (n >= w) ? 0 : (v >> n);
        ecf = (n <= w) ? bit'((v >> (n - 1)) & 1) : 1'b0;
      end
      default: begin
        top = (v >> (w - 1)) & 1;
        sv  = (top != 0) ? v - (64'd1 << w) : v;
        rr  = (n >= w) ? ((top != 0) ? mask : 0) : ((sv >>> n) & mask);
        ecf = (n <= w) ? bit'((v >> (n - 1)) & 1) : bit'(top);
      end
    endcase
    r = 16'(rr);
    top = (rr >> (w - 1)) & 1;
    if (o[0] == 1'b0)   eof = bit'(top) ^ ecf;
    else if (o == 3'd7) eof = 1'b0;
    else                eof = bit'(top ^ ((rr >> (w - 2)) & 1));
    if (o == 3'd0 || o == 3'd1) {esf, ezf, epf} = fi[2:0];
    else begin
      esf = bit'(top);
      ezf = (rr == 0);
      epf = ~^rr[7:0];
    end
  endtask

  task automatic run_op(input logic [2:0] o, input bit w16, input bit use_cl, input int n,
                        input logic [15:0] v, input bit c, input logic [3:0] fi);
    logic [15:0] er;
    bit ecf, eof, esf, ezf, epf;
    int k;
    string rq, fq;
    model(o, w16, n, v, c, fi, er, ecf, eof, esf, ezf, epf);
    case (o)
      3'd0, 3'd1: rq = "R4";
      3'd2, 3'd3: rq = "R5";
      3'd5:       rq = "R2";
      3'd7:       rq = "R3";
      default:    rq = "R1";
    endcase
    if (n == 0) rq = "R7";
    if (use_cl) rq = {rq, "+R6"};
    fq = (n == 0) ? "R7" : ((o == 3'd0 || o == 3'd1) ? "R9" : "R8");
    @(negedge clk);
    op = o; wide = w16; cnt_from_cl = use_cl; operand = v; cf_in = c;
    {of_in, sf_in, zf_in, pf_in} = fi;
    cnt_imm = use_cl ? 8'(~n) : 8'(n);
    cl_val  = use_cl ? 8'(n) : 8'(~n + 3);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k <= n + 4) begin
      @(posedge clk); @(negedge clk);
      k++;
    end
    check("R7", "done latency", k, n);
    check(rq, "result", result, er);
    check(w16 ? rq : "R8", "cf", cf, ecf);
    check((n == 0) ? "R7" : "R10", "of", of, eof);
    check(fq, "sf", sf, esf);
    check(fq, "zf", zf, ezf);
    check(fq, "pf", pf, epf);
  endtask

  function automatic logic [15:0] pattern(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h0080;
      3: return 16'h8001;
      default: return 16'(i * 16'h9E37) ^ 16'h5A3C;
    endcase
  endfunction

  initial begin
    #1900000;
    fails++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "done", done, 0);
    check("R12", "busy", busy, 0);
    check("R12", "result", result, 0);
    check("R12", "flags", {cf, of, sf, zf, pf}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int w16 = 0; w16 < 2; w16++)
      for (int o = 0; o < 8; o++)
        for (int n = 0; n <= (w16 ? 18 : 10); n++)
          for (int p = 0; p < (w16 ? 6 : 12); p++)
            for (int c = 0; c < 2; c++)
              run_op(3'(o), bit'(w16), bit'(n & 1), n, pattern(p + n), bit'(c), 4'(p + n + c));

    // R6 large count through the register source
    run_op(3'd2, 1'b1, 1'b1, 200, 16'hC35A, 1'b1, 4'h5);
    run_op(3'd7, 1'b0, 1'b1, 130, 16'h0081, 1'b0, 4'hA);

    // R11 start while busy is ignored
    begin
      int k;
      @(negedge clk);
      op = 3'd0; wide = 1'b1; cnt_from_cl = 1'b0; cnt_imm = 8'd5;
      operand = 16'h1234; cf_in = 1'b0; {of_in, sf_in, zf_in, pf_in} = 4'h0;
      start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      @(posedge clk); @(negedge clk);
      op = 3'd5; operand = 16'hFFFF; cnt_imm = 8'd0; start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      k = 2;
      while (!done && k < 12) begin
        @(posedge clk); @(negedge clk);
        k++;
      end
      check("R11", "done latency", k, 5);
      check("R11", "result", result, 16'h4682);
      check("R11", "cf", cf, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule